// File: doc/BRIEF.md
# Chunked Outbound Address Window Decoder

This block decides whether a CPU-side address is forwarded to the PCI side. The top 256 MB of the 32-bit space, starting at 0xF0000000, is split into 32 equal chunks of 8 MB. Each chunk has one bit in a window-enable register. A two-bit mode field in a control register gates every chunk at once. The forwarding decision is combinational from the address and the two registers, so it follows a register write in the first cycle after that write.

The same block also classifies inbound bus-master addresses. An inbound address lands in system memory below the first forwardable chunk, and in PCI memory from there up to the top of the space. Software loads the two registers through a single-cycle write port and reads them back through a combinational read port. The block does not carry out bus transactions: its outputs are hit and target indications only.

Top module: `wdec_window`

## Requirements
- R1: `fwd_chunk` always equals address bits [27:23] of `cpu_addr`, which is the chunk index inside the window region.
- R2: `fwd_hit` is 1 exactly when `cpu_addr[31:28]` is 0xF, the enable bit selected by the chunk index is 1, and the gate is on.
- R3: A write with `wr_sel`=0 stores `wr_data` AND 0x7FFFFFFE in the enable register, so chunks 0 and 31 never hit. Reading with `rd_sel`=0 returns the stored value.
- R4: The gate is on only when control bits [8:7] are binary 01. The values 00, 10 and 11 turn off every chunk, whatever the enable register holds, and the other control bits have no effect on forwarding.
- R5: A write with `wr_sel`=1 stores all 32 bits of `wr_data` in the control register. Reading with `rd_sel`=1 returns those bits unchanged.
- R6: A register write takes effect at the clock edge on which `wr_en` is sampled high. From the next cycle on, `fwd_hit` and `rd_data` reflect the new value.
- R7: Any `cpu_addr` whose top nibble is not 0xF gives `fwd_hit`=0.
- R8: An inbound `bm_addr` below 0xF0800000 raises only `bm_to_sys`. Any inbound address from 0xF0800000 up to 0xFFFFFFFF raises only `bm_to_pci`.
- R9: After reset, both registers read 0 and no address hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = enable register, 1 = control register |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 = enable register, 1 = control register |
| rd_data | output | 32 | Read data (combinational) |
| cpu_addr | input | 32 | Outbound CPU-side address |
| fwd_hit | output | 1 | Address is forwarded to the PCI side |
| fwd_chunk | output | 5 | Chunk index of `cpu_addr` |
| bm_addr | input | 32 | Inbound bus-master address |
| bm_to_sys | output | 1 | Inbound target is system memory |
| bm_to_pci | output | 1 | Inbound target is PCI memory |

## Verification
The outbound decision is swept over all 32 chunks for each of four enable patterns: all ones, two alternating patterns and a sparse two-bit pattern. Each pattern is combined with all four mode values, and the bits outside the mode field are scrambled. This separates a wrong index decode, a wrong mode decode and a leak through the protected edge chunks, because each of these errors changes a different set of positions in the hit map. Addresses with every top nibble other than 0xF check that the region decode does not depend on the chunk bits. Inbound addresses on both sides of 0xF0800000 and at the ends of the space expose an off-by-one in the system-memory limit.

// File: rtl/wdec_pkg.sv
package wdec_pkg;
    // Register selector shared by the write and read ports.
    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_CTRL   = 1'b1
    } reg_sel_e;

    // Inbound target classification.
    typedef enum logic [1:0] {
        TGT_SYS = 2'b01,
        TGT_PCI = 2'b10
    } bm_tgt_e;

    // Enable mask with the lowest and highest chunk bits forced to zero.
    function automatic logic [31:0] edge_clear_mask(input int nchunk);
        logic [31:0] m;
        m = '0;
        for (int i = 1; i < nchunk - 1; i++) m[i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/wdec_regs.sv
module wdec_regs
    import wdec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NCHUNK = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCHUNK-1:0] enable_q,
    output logic [DATA_W-1:0] ctrl_q
);
    localparam logic [31:0] EN_MASK_FULL = edge_clear_mask(NCHUNK);
    localparam logic [NCHUNK-1:0] EN_MASK = EN_MASK_FULL[NCHUNK-1:0];

    reg_sel_e wsel, rsel;
    assign wsel = reg_sel_e'(wr_sel);
    assign rsel = reg_sel_e'(rd_sel);

    // Register state process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            ctrl_q   <= '0;
        end else if (wr_en) begin
            unique case (wsel)
                SEL_ENABLE: enable_q <= wr_data[NCHUNK-1:0] & EN_MASK;
                SEL_CTRL:   ctrl_q   <= wr_data;
            endcase
        end
    end

    // Read-back process.
    always_comb begin
        rd_data = '0;
        unique case (rsel)
            SEL_ENABLE: rd_data[NCHUNK-1:0] = enable_q;
            SEL_CTRL:   rd_data = ctrl_q;
        endcase
    end
endmodule

// File: rtl/wdec_gate.sv
module wdec_gate #(
    parameter int          DATA_W   = 32,
    parameter int          GATE_LSB = 7,
    parameter logic [1:0]  GATE_ON  = 2'b01
) (
    input  logic [DATA_W-1:0] ctrl,
    output logic              gate_on
);
    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^ctrl;

    always_comb begin
        gate_on = (ctrl[GATE_LSB+1:GATE_LSB] == GATE_ON);
    end
endmodule

// File: rtl/wdec_outbound.sv
module wdec_outbound #(
    parameter int         ADDR_W      = 32,
    parameter int         CHUNK_SHIFT = 23,
    parameter int         CHUNK_IDX_W = 5,
    parameter logic [3:0] REGION_TAG  = 4'hF
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [(1<<CHUNK_IDX_W)-1:0] enable,
    input  logic                        gate_on,
    output logic                        hit,
    output logic [CHUNK_IDX_W-1:0]      chunk
);
    localparam int NCHUNK  = 1 << CHUNK_IDX_W;
    localparam int TAG_LSB = CHUNK_SHIFT + CHUNK_IDX_W;

    logic              in_region;
    logic [NCHUNK-1:0] chunk_hit;
    logic              unused_low;

    assign unused_low = ^addr[CHUNK_SHIFT-1:0];
    assign in_region  = (addr[ADDR_W-1:TAG_LSB] == REGION_TAG);
    assign chunk      = addr[TAG_LSB-1:CHUNK_SHIFT];

    // One comparator per chunk window.
    for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
        assign chunk_hit[i] = in_region && enable[i] &&
                              (chunk == CHUNK_IDX_W'(i));
    end

    assign hit = gate_on && (|chunk_hit);
endmodule

// File: rtl/wdec_inbound.sv
module wdec_inbound
    import wdec_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] SYS_LIMIT = 32'hF080_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              to_sys,
    output logic              to_pci
);
    bm_tgt_e tgt;

    always_comb begin
        if (addr < SYS_LIMIT[ADDR_W-1:0]) tgt = TGT_SYS;
        else                               tgt = TGT_PCI;
    end

    assign to_sys = (tgt == TGT_SYS);
    assign to_pci = (tgt == TGT_PCI);
endmodule

// File: rtl/wdec_window.sv
module wdec_window #(
    parameter int         ADDR_W      = 32,
    parameter int         DATA_W      = 32,
    parameter int         CHUNK_SHIFT = 23,
    parameter int         CHUNK_IDX_W = 5,
    parameter logic [3:0] REGION_TAG  = 4'hF,
    parameter int         GATE_LSB    = 7,
    parameter logic [1:0] GATE_ON     = 2'b01
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_sel,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   rd_sel,
    output logic [DATA_W-1:0]      rd_data,
    input  logic [ADDR_W-1:0]      cpu_addr,
    output logic                   fwd_hit,
    output logic [CHUNK_IDX_W-1:0] fwd_chunk,
    input  logic [ADDR_W-1:0]      bm_addr,
    output logic                   bm_to_sys,
    output logic                   bm_to_pci
);
    localparam int NCHUNK  = 1 << CHUNK_IDX_W;
    localparam int TAG_LSB = CHUNK_SHIFT + CHUNK_IDX_W;
    localparam logic [ADDR_W-1:0] REGION_BASE = ADDR_W'(REGION_TAG) << TAG_LSB;
    localparam logic [ADDR_W-1:0] CHUNK_BYTES = ADDR_W'(1) << CHUNK_SHIFT;
    localparam logic [31:0]       SYS_LIMIT   = 32'(REGION_BASE + CHUNK_BYTES);

    logic [NCHUNK-1:0] enable_q;
    logic [DATA_W-1:0] ctrl_q;
    logic              gate_on;

    wdec_regs #(.DATA_W(DATA_W), .NCHUNK(NCHUNK)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .enable_q (enable_q),
        .ctrl_q   (ctrl_q)
    );

    wdec_gate #(.DATA_W(DATA_W), .GATE_LSB(GATE_LSB), .GATE_ON(GATE_ON)) u_gate (
        .ctrl    (ctrl_q),
        .gate_on (gate_on)
    );

    wdec_outbound #(
        .ADDR_W(ADDR_W), .CHUNK_SHIFT(CHUNK_SHIFT),
        .CHUNK_IDX_W(CHUNK_IDX_W), .REGION_TAG(REGION_TAG)
    ) u_out (
        .addr    (cpu_addr),
        .enable  (enable_q),
        .gate_on (gate_on),
        .hit     (fwd_hit),
        .chunk   (fwd_chunk)
    );

    wdec_inbound #(.ADDR_W(ADDR_W), .SYS_LIMIT(SYS_LIMIT)) u_in (
        .addr   (bm_addr),
        .to_sys (bm_to_sys),
        .to_pci (bm_to_pci)
    );
endmodule

// File: rtl/wdec_window_checker.sv
module wdec_window_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_sel,
    input logic [31:0] rd_data,
    input logic [31:0] cpu_addr,
    input logic        fwd_hit,
    input logic [31:0] bm_addr,
    input logic        bm_to_sys,
    input logic        bm_to_pci,
    input logic [31:0] ctrl_q
);
    // R7: nothing outside the top region is forwarded.
    a_r7_outside_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[31:28] != 4'hF) |-> !fwd_hit);

    // R3: the edge chunks never hit.
    a_r3_edge_chunks_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[27:23] == 5'd0 || cpu_addr[27:23] == 5'd31) |-> !fwd_hit);

    // R3: the enable read-back never shows the edge bits.
    a_r3_readback_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 1'b0) |-> (rd_data[0] == 1'b0 && rd_data[31] == 1'b0));

    // R4: a hit needs the mode field at 01.
    a_r4_gate_needed: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hit |-> (ctrl_q[8:7] == 2'b01));

    // R8: exactly one inbound target.
    a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({bm_to_sys, bm_to_pci}) == 1);

    // R8: low addresses go to system memory.
    a_r8_low_is_sys: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_addr < 32'hF080_0000) |-> bm_to_sys);

    // R9: first cycle out of reset forwards nothing.
    a_r9_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> !fwd_hit);
endmodule

bind wdec_window wdec_window_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .cpu_addr  (cpu_addr),
    .fwd_hit   (fwd_hit),
    .bm_addr   (bm_addr),
    .bm_to_sys (bm_to_sys),
    .bm_to_pci (bm_to_pci),
    .ctrl_q    (ctrl_q)
);

// File: tb/wdec_window_test.sv
`timescale 1ns/1ps
module wdec_window_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] cpu_addr = '0;
    logic        fwd_hit;
    logic [4:0]  fwd_chunk;
    logic [31:0] bm_addr = '0;
    logic        bm_to_sys;
    logic        bm_to_pci;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    wdec_window uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .cpu_addr(cpu_addr), .fwd_hit(fwd_hit), .fwd_chunk(fwd_chunk),
        .bm_addr(bm_addr), .bm_to_sys(bm_to_sys), .bm_to_pci(bm_to_pci)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic read_reg(input logic sel, input string req, input logic [31:0] exp);
        rd_sel = sel;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic probe(input logic [31:0] a, input logic exp_hit, input string req);
        cpu_addr = a;
        #1;
        check(req, {31'd0, fwd_hit}, {31'd0, exp_hit});
    endtask

    function automatic logic [31:0] make_addr(input logic [3:0] tag, input int c);
        return {tag, 5'(c), 23'((c * 24593) & 32'h7F_FFFF)};
    endfunction

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] masks [4];
        masks[0] = 32'hFFFF_FFFF;
        masks[1] = 32'hAAAA_AAAA;
        masks[2] = 32'h5555_5555;
        masks[3] = 32'h0001_0081;

        repeat (3) @(negedge clk);
        // R9: reset state.
        read_reg(1'b0, "R9 enable after reset", 32'h0);
        read_reg(1'b1, "R9 control after reset", 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 32; c++) probe(make_addr(4'hF, c), 1'b0, "R9 no hit after reset");

        for (int m = 0; m < 4; m++) begin
            logic [31:0] en_exp;
            en_exp = masks[m] & 32'h7FFF_FFFE;
            write_reg(1'b0, masks[m]);
            read_reg(1'b0, "R3 enable readback masked", en_exp);
            for (int mode = 0; mode < 4; mode++) begin
                logic [31:0] ctrl_val;
                ctrl_val = ((32'h9E37_79B9 * (m + 1)) & ~32'h180) | (32'(mode) << 7);
                write_reg(1'b1, ctrl_val);
                read_reg(1'b1, "R5 control readback", ctrl_val);
                for (int c = 0; c < 32; c++) begin
                    logic exp_h;
                    exp_h = (mode == 1) && en_exp[c];
                    cpu_addr = make_addr(4'hF, c);
                    #1;
                    check("R1 chunk index", {27'd0, fwd_chunk}, 32'(c));
                    check((mode == 1) ? "R2 hit map" : "R4 gate off", {31'd0, fwd_hit}, {31'd0, exp_h});
                end
            end
        end

        // R7: outside region, all enabled, gate on.
        write_reg(1'b0, 32'hFFFF_FFFF);
        write_reg(1'b1, 32'h0000_0080);
        for (int t = 0; t < 15; t++)
            for (int c = 0; c < 32; c += 5)
                probe(make_addr(4'(t), c), 1'b0, "R7 outside region");

        // R6: a write changes the decision in the next cycle.
        cpu_addr = make_addr(4'hF, 7);
        #1;
        check("R6 hit before write", {31'd0, fwd_hit}, 32'd1);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0000_0000;
        #1;
        check("R6 hit unchanged before edge", {31'd0, fwd_hit}, 32'd1);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R6 hit cleared after edge", {31'd0, fwd_hit}, 32'd0);
        write_reg(1'b0, 32'h0000_0080);
        check("R6 hit restored", {31'd0, fwd_hit}, 32'd1);
        write_reg(1'b1, 32'h0000_0100);
        check("R6 control write gates off", {31'd0, fwd_hit}, 32'd0);

        // R8: inbound classification.
        begin
            logic [31:0] pts [10];
            pts[0] = 32'h0000_0000; pts[1] = 32'h7FFF_FFFF; pts[2] = 32'hEFFF_FFFF;
            pts[3] = 32'hF000_0000; pts[4] = 32'hF07F_FFFF; pts[5] = 32'hF080_0000;
            pts[6] = 32'hF080_0001; pts[7] = 32'hFF7F_FFFF; pts[8] = 32'hFF80_0000;
            pts[9] = 32'hFFFF_FFFF;
            for (int i = 0; i < 10; i++) begin
                bm_addr = pts[i];
                #1;
                check("R8 inbound target", {30'd0, bm_to_pci, bm_to_sys},
                      (pts[i] < 32'hF080_0000) ? 32'd1 : 32'd2);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule